// File: doc/BRIEF.md
# Multiplexed ADC Convert Pulse Scheduler

This block serves an analog input module that shares one converter between several channels through a multiplexer. Each accepted sample pulse starts a burst of single-cycle convert strobes, one per enabled channel. Each strobe carries the index of the channel to acquire. The gap between strobes is chosen when the burst starts.

By default the gap is the converter's minimum conversion time plus a settling pad, so the channels are taken close together and the scan approximates simultaneous sampling. If the padded burst would not fit inside the sample period, the gap becomes the sample period divided evenly by the channel count. Software can instead request a fixed gap, which overrides both automatic choices. One pad value is shared by every module the scheduler serves.

A pulse that arrives while strobes are still pending does not start a burst. It only raises a one-cycle overrun flag.

Top module: `scan_convert_sched`

## Requirements
- R1: While no strobes are pending, a sample pulse with a non-zero channel count is accepted. The first convert strobe and channel index 0 appear in the cycle after the clock edge that samples the pulse.
- R2: An accepted burst with channel count N produces exactly N one-cycle strobes. Strobe j carries channel index j, for j = 0 to N-1. The index changes only with a strobe, and after the burst it holds N-1 until the next accepted pulse.
- R3: Padded spacing applies when (conversion time + pad) × N is no more than the sample period. Strobes are then (conversion time + pad) cycles apart, and the mode output reads 0.
- R4: When the padded burst does not fit, strobes are spaced by the integer quotient of sample period / N, with a floor of 1 cycle, and the mode output reads 1.
- R5: When the explicit-rate enable is high at acceptance, strobes are spaced by the explicit gap, with a gap of 0 treated as 1. The mode output reads 2 regardless of whether the padded burst would fit.
- R6: A sample pulse sampled while strobes are pending raises the overrun output for exactly the following cycle and leaves the running burst unchanged.
- R7: A sample pulse with a channel count of 0 produces no strobe and leaves the channel index unchanged. A channel count above MAX_CH is treated as MAX_CH.
- R8: The channel count, timing inputs and explicit-rate settings are captured at acceptance. Changing them during a burst has no effect on that burst.
- R9: During and right after reset, the strobe, overrun and channel index are 0 and the mode reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_pulse | input | 1 | Sample pulse, one cycle |
| chan_cnt | input | CNT_W | Number of enabled channels |
| adc_cyc | input | TW | Minimum conversion time in cycles |
| period_cyc | input | TW | Sample period in cycles |
| pad_cyc | input | TW | Settling pad in cycles |
| fix_en | input | 1 | Use the explicit gap |
| fix_cyc | input | TW | Explicit gap in cycles |
| cnv_strobe | output | 1 | Convert strobe |
| cnv_chan | output | IDX_W | Channel index for the current or last strobe |
| spc_mode | output | 2 | Spacing in effect: 0 padded, 1 even, 2 explicit |
| overrun | output | 1 | Pulse rejected during a busy burst |

## Verification
The first strobe and the overrun flag each appear one cycle after the edge that samples the pulse. Strobe j follows at j × gap cycles after the first strobe. The bench drives inputs on falling edges and samples at falling edges, counting the offset from the first falling edge after the pulse's capture edge. It compares the offset of every observed strobe with the gap it computed from the inputs. It also checks that no strobe appears beyond the expected count, within a window that extends past the burst's end.

// File: rtl/scan_convert_pkg.sv
package scan_convert_pkg;

    typedef enum logic [1:0] {
        MODE_PAD   = 2'd0,
        MODE_EVEN  = 2'd1,
        MODE_FIXED = 2'd2
    } spc_mode_e;

endpackage

// File: rtl/scan_spacing_sel.sv
module scan_spacing_sel
    import scan_convert_pkg::*;
#(
    parameter int MAX_CH = 16,
    parameter int TW     = 24,
    parameter int CNT_W  = $clog2(MAX_CH + 1),
    parameter int SW     = TW + 1
) (
    input  logic [CNT_W-1:0] chan_cnt,
    input  logic [TW-1:0]    adc_cyc,
    input  logic [TW-1:0]    period_cyc,
    input  logic [TW-1:0]    pad_cyc,
    input  logic             fix_en,
    input  logic [TW-1:0]    fix_cyc,
    output logic [CNT_W-1:0] cnt_eff,
    output logic [SW-1:0]    spacing,
    output spc_mode_e        mode
);
    localparam int PW = SW + CNT_W;

    logic [SW-1:0]    padded;
    logic [PW-1:0]    need;
    logic             fits;
    logic [CNT_W-1:0] divisor;
    logic [TW-1:0]    even;

    always_comb begin
        cnt_eff = (chan_cnt > CNT_W'(MAX_CH)) ? CNT_W'(MAX_CH) : chan_cnt;
        padded  = SW'(adc_cyc) + SW'(pad_cyc);
        need    = PW'(padded) * PW'(cnt_eff);
        fits    = need <= PW'(period_cyc);
        divisor = (cnt_eff == '0) ? CNT_W'(1) : cnt_eff;
        even    = period_cyc / TW'(divisor);

        if (fix_en) begin
            mode    = MODE_FIXED;
            spacing = (fix_cyc == '0) ? SW'(1) : SW'(fix_cyc);
        end else if (fits) begin
            mode    = MODE_PAD;
            spacing = (padded == '0) ? SW'(1) : padded;
        end else begin
            mode    = MODE_EVEN;
            spacing = (even == '0) ? SW'(1) : SW'(even);
        end
    end

endmodule

// File: rtl/scan_burst_ctrl.sv
module scan_burst_ctrl
    import scan_convert_pkg::*;
#(
    parameter int MAX_CH = 16,
    parameter int CNT_W  = $clog2(MAX_CH + 1),
    parameter int IDX_W  = (MAX_CH > 1) ? $clog2(MAX_CH) : 1,
    parameter int SW     = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_pulse,
    input  logic [CNT_W-1:0] cnt_eff,
    input  logic [SW-1:0]    sel_spacing,
    input  spc_mode_e        sel_mode,
    output logic             strobe,
    output logic [IDX_W-1:0] chan,
    output logic             overrun,
    output spc_mode_e        mode,
    output logic             busy
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] left;
        logic [IDX_W-1:0] chan;
        logic [SW-1:0]    tmr;
        logic [SW-1:0]    spc;
        logic             strobe;
        logic             ovr;
        spc_mode_e        mode;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        st_d.ovr    = 1'b0;
        if (st_q.busy) begin
            if (smp_pulse) begin
                st_d.ovr = 1'b1;
            end
            if (st_q.tmr != '0) begin
                st_d.tmr = st_q.tmr - SW'(1);
            end else begin
                st_d.strobe = 1'b1;
                st_d.chan   = st_q.chan + IDX_W'(1);
                st_d.left   = st_q.left - CNT_W'(1);
                st_d.tmr    = st_q.spc - SW'(1);
                if (st_q.left == CNT_W'(1)) begin
                    st_d.busy = 1'b0;
                end
            end
        end else if (smp_pulse && cnt_eff != '0) begin
            st_d.strobe = 1'b1;
            st_d.chan   = '0;
            st_d.spc    = sel_spacing;
            st_d.mode   = sel_mode;
            st_d.tmr    = sel_spacing - SW'(1);
            st_d.left   = cnt_eff - CNT_W'(1);
            st_d.busy   = cnt_eff > CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy   <= 1'b0;
            st_q.left   <= '0;
            st_q.chan   <= '0;
            st_q.tmr    <= '0;
            st_q.spc    <= '0;
            st_q.strobe <= 1'b0;
            st_q.ovr    <= 1'b0;
            st_q.mode   <= MODE_PAD;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe  = st_q.strobe;
    assign chan    = st_q.chan;
    assign overrun = st_q.ovr;
    assign mode    = st_q.mode;
    assign busy    = st_q.busy;

endmodule

// File: rtl/scan_convert_sched.sv
module scan_convert_sched
    import scan_convert_pkg::*;
#(
    parameter int MAX_CH = 16,
    parameter int TW     = 24,
    parameter int CNT_W  = $clog2(MAX_CH + 1),
    parameter int IDX_W  = (MAX_CH > 1) ? $clog2(MAX_CH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_pulse,
    input  logic [CNT_W-1:0] chan_cnt,
    input  logic [TW-1:0]    adc_cyc,
    input  logic [TW-1:0]    period_cyc,
    input  logic [TW-1:0]    pad_cyc,
    input  logic             fix_en,
    input  logic [TW-1:0]    fix_cyc,
    output logic             cnv_strobe,
    output logic [IDX_W-1:0] cnv_chan,
    output logic [1:0]       spc_mode,
    output logic             overrun
);
    localparam int SW = TW + 1;

    logic [CNT_W-1:0] cnt_eff;
    logic [SW-1:0]    sel_spacing;
    spc_mode_e        sel_mode;
    spc_mode_e        cur_mode;
    logic             burst_busy;

    scan_spacing_sel #(
        .MAX_CH(MAX_CH), .TW(TW), .CNT_W(CNT_W), .SW(SW)
    ) u_sel (
        .chan_cnt  (chan_cnt),
        .adc_cyc   (adc_cyc),
        .period_cyc(period_cyc),
        .pad_cyc   (pad_cyc),
        .fix_en    (fix_en),
        .fix_cyc   (fix_cyc),
        .cnt_eff   (cnt_eff),
        .spacing   (sel_spacing),
        .mode      (sel_mode)
    );

    scan_burst_ctrl #(
        .MAX_CH(MAX_CH), .CNT_W(CNT_W), .IDX_W(IDX_W), .SW(SW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_pulse  (smp_pulse),
        .cnt_eff    (cnt_eff),
        .sel_spacing(sel_spacing),
        .sel_mode   (sel_mode),
        .strobe     (cnv_strobe),
        .chan       (cnv_chan),
        .overrun    (overrun),
        .mode       (cur_mode),
        .busy       (burst_busy)
    );

    assign spc_mode = cur_mode;

endmodule

// File: rtl/scan_convert_sched_chk.sv
module scan_convert_sched_chk #(
    parameter int CNT_W = 5,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_pulse,
    input logic [CNT_W-1:0] chan_cnt,
    input logic             cnv_strobe,
    input logic [IDX_W-1:0] cnv_chan,
    input logic             overrun,
    input logic             burst_busy
);
    // R1
    first_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_pulse && !burst_busy && chan_cnt != '0) |=> (cnv_strobe && cnv_chan == '0));

    // R2
    chan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_strobe && cnv_chan != '0) |-> (cnv_chan == IDX_W'($past(cnv_chan) + 1'b1)));

    // R2
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnv_strobe |-> $stable(cnv_chan));

    // R6
    overrun_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_pulse && burst_busy) |=> overrun);

    // R6
    overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_pulse || !burst_busy) |=> !overrun);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_busy && !(smp_pulse && chan_cnt != '0)) |=> !cnv_strobe);

endmodule

bind scan_convert_sched scan_convert_sched_chk #(
    .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_pulse (smp_pulse),
    .chan_cnt  (chan_cnt),
    .cnv_strobe(cnv_strobe),
    .cnv_chan  (cnv_chan),
    .overrun   (overrun),
    .burst_busy(burst_busy)
);

// File: tb/scan_convert_sched_test.sv
module scan_convert_sched_test;
    localparam int MAX_CH = 16;
    localparam int TW     = 24;
    localparam int CNT_W  = $clog2(MAX_CH + 1);
    localparam int IDX_W  = $clog2(MAX_CH);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             smp_pulse = 1'b0;
    logic [CNT_W-1:0] chan_cnt = '0;
    logic [TW-1:0]    adc_cyc = '0;
    logic [TW-1:0]    period_cyc = '0;
    logic [TW-1:0]    pad_cyc = '0;
    logic             fix_en = 1'b0;
    logic [TW-1:0]    fix_cyc = '0;
    logic             cnv_strobe;
    logic [IDX_W-1:0] cnv_chan;
    logic [1:0]       spc_mode;
    logic             overrun;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    scan_convert_sched #(.MAX_CH(MAX_CH), .TW(TW)) uut (
        .clk(clk), .rst_n(rst_n), .smp_pulse(smp_pulse), .chan_cnt(chan_cnt),
        .adc_cyc(adc_cyc), .period_cyc(period_cyc), .pad_cyc(pad_cyc),
        .fix_en(fix_en), .fix_cyc(fix_cyc), .cnv_strobe(cnv_strobe),
        .cnv_chan(cnv_chan), .spc_mode(spc_mode), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // Drives one accepted or rejected pulse and watches the burst.
    task automatic run_burst(input int cnt, input int adc, input int per, input int pad,
                             input bit fen, input int fgap, input int exp_gap,
                             input int exp_n, input int exp_mode, input int ovr_at,
                             input string rq);
        int seen = 0;
        int win;
        chan_cnt = CNT_W'(cnt); adc_cyc = TW'(adc); period_cyc = TW'(per);
        pad_cyc = TW'(pad); fix_en = fen; fix_cyc = TW'(fgap);
        @(negedge clk) smp_pulse = 1'b1;
        @(negedge clk) smp_pulse = 1'b0;
        win = (exp_n > 0 ? exp_n * exp_gap : 0) + 8;
        if (exp_n > 0) chk(int'(spc_mode) == exp_mode, {rq, " mode"}, int'(spc_mode), exp_mode);
        for (int off = 0; off < win; off++) begin
            if (cnv_strobe) begin
                chk(seen < exp_n, {rq, " strobe count"}, seen + 1, exp_n);
                chk(off == seen * exp_gap, {rq, " strobe offset"}, off, seen * exp_gap);
                chk(int'(cnv_chan) == seen, {rq, " channel index"}, int'(cnv_chan), seen);
                seen++;
            end
            if (ovr_at >= 0 && off == ovr_at) begin
                smp_pulse = 1'b1;
                // R8: settings moved during the burst
                adc_cyc = TW'(3); pad_cyc = TW'(0); chan_cnt = CNT_W'(2);
            end
            if (ovr_at >= 0 && off == ovr_at + 1) begin
                smp_pulse = 1'b0;
                chk(overrun == 1'b1, "R6 overrun raised", int'(overrun), 1);
            end
            if (ovr_at >= 0 && off == ovr_at + 2)
                chk(overrun == 1'b0, "R6 overrun one cycle", int'(overrun), 0);
            @(negedge clk);
        end
        chk(seen == exp_n, {rq, " total strobes"}, seen, exp_n);
        if (exp_n > 0)
            chk(int'(cnv_chan) == exp_n - 1, "R2 index held", int'(cnv_chan), exp_n - 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(cnv_strobe == 1'b0, "R9 strobe in reset", int'(cnv_strobe), 0);
        chk(overrun == 1'b0, "R9 overrun in reset", int'(overrun), 0);
        chk(cnv_chan == '0, "R9 index in reset", int'(cnv_chan), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(spc_mode == 2'd0, "R9 mode after reset", int'(spc_mode), 0);
        chk(cnv_strobe == 1'b0, "R9 strobe after reset", int'(cnv_strobe), 0);
    endtask

    task automatic t_padded();      // R1 R2 R3
        run_burst(4, 5, 100, 3, 1'b0, 0, 8, 4, 0, -1, "R3 padded");
    endtask
    task automatic t_padded_edge(); // R3 exact fit
        run_burst(4, 15, 100, 10, 1'b0, 0, 25, 4, 0, -1, "R3 exact fit");
    endtask
    task automatic t_zero_cnt();    // R7 index stays 3
        run_burst(0, 5, 100, 3, 1'b0, 0, 1, 0, 0, -1, "R7 zero count");
        chk(int'(cnv_chan) == 3, "R7 index unchanged", int'(cnv_chan), 3);
    endtask
    task automatic t_even();        // R4
        run_burst(4, 20, 100, 10, 1'b0, 0, 25, 4, 1, -1, "R4 even");
        run_burst(3, 20, 50, 10, 1'b0, 0, 16, 3, 1, -1, "R4 even remainder");
    endtask
    task automatic t_even_floor();  // R4 quotient 0 -> 1
        run_burst(4, 1, 2, 1, 1'b0, 0, 1, 4, 1, -1, "R4 floor");
    endtask
    task automatic t_fixed();       // R5
        run_burst(5, 2, 1000, 2, 1'b1, 7, 7, 5, 2, -1, "R5 explicit");
        run_burst(3, 2, 1000, 2, 1'b1, 0, 1, 3, 2, -1, "R5 explicit zero");
    endtask
    task automatic t_single();      // R1 R2
        run_burst(1, 4, 100, 4, 1'b0, 0, 8, 1, 0, -1, "R1 single");
    endtask
    task automatic t_clamp();       // R7 clamp
        run_burst(20, 1, 100, 1, 1'b0, 0, 2, 16, 0, -1, "R7 clamp");
    endtask
    task automatic t_overrun();     // R6 R8
        run_burst(4, 5, 100, 5, 1'b0, 0, 10, 4, 0, 5, "R6 R8 overrun");
    endtask

    initial begin
        t_reset();
        t_padded();
        t_padded_edge();
        t_zero_cnt();
        t_even();
        t_even_floor();
        t_fixed();
        t_single();
        t_clamp();
        t_overrun();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule